// File: doc/BRIEF.md
# Memory Zero-Fill Engine with Three-Way Write Path Selector

This block guards a single AXI4 memory port. Inside it, a zero-fill engine clears a memory region. On its own write master it issues full-width incrementing bursts of all-zero data, starting at address 0 and ending at the parameter `MAX_ADDR`. The same memory port is shared with two external AXI4 masters: an automatic traffic tester and a host pass-through path. A small selector decides which of the three masters owns the port.

Software or a sequencer raises `scrub_en` to start a clear. The engine then walks the region in bursts of up to eight 64-byte beats (512 bytes per burst). It keeps exactly one burst in flight. The last burst is shortened so that its final beat ends at `MAX_ADDR`. The engine shows its live state code, the base address of the current burst, a done flag and a sticky error flag. The done flag stays up until `scrub_en` is dropped. Dropping it returns the engine to its resting state and clears the address.

The engine's states are IDLE (resting), ADDR (presenting a burst address), DATA (streaming zero beats), RESP (waiting for the write response) and DONE (range cleared). Its transitions are:
- start (IDLE to ADDR, when enable is high);
- addr_accept (ADDR to DATA, on address handshake);
- last_beat (DATA to RESP, on the handshake of the final beat);
- next_burst (RESP to ADDR, on a response when more of the range remains);
- finish (RESP to DONE, on the response to the final burst);
- release (DONE to IDLE, when enable is low).

Top module: `mem_zero_fill`

## Requirements
- R1: After reset the status reads state code 0 (IDLE), address 0, done 0 and error 0. The engine presents no write address.
- R2: When `scrub_en` is high in IDLE, the engine moves to ADDR (state code 1) on the next clock edge. It then presents a burst at address 0 on the memory port.
- R3: Burst k starts at address k*512 with `awlen` 7 (eight beats). The final burst instead carries `awlen` = (remaining beats − 1), where remaining beats = (MAX_ADDR+1)/64 − 8k. Its last beat therefore covers the bytes that end at `MAX_ADDR`.
- R4: Every scrub data beat carries all-zero `wdata` and an all-ones `wstrb`. `wlast` is high exactly on beat number `awlen`+1 of its burst and on no other beat.
- R5: A new write address is offered only after the write response of the previous burst has completed its handshake, so at most one burst is outstanding. A pending address and its value do not change until it is accepted.
- R6: After the response to the final burst, the state code is 4 (DONE) and `scrub_done` is 1. Both hold while `scrub_en` stays high. One edge after `scrub_en` goes low, the state is 0, the address is 0 and done is 0.
- R7: A write response other than 0 (OKAY) sets `scrub_err`. The flag stays set for the rest of the run, and the clear still covers the full range. The flag is cleared when the next run starts.
- R8: Port ownership is priority-ordered: `scrub_en` high selects the engine, otherwise `tst_en` high selects the tester, otherwise the host path owns the port. The owner's request signals (`awaddr`, `awvalid`, `arvalid`, `bready`, ...) appear on the memory port in the same cycle.
- R9: A master that does not own the port sees `awready`, `wready`, `arready`, `bvalid` and `rvalid` held at 0.
- R10: The state code reads 1 while an address is offered, 2 while data beats are offered and 3 while the response is awaited. `scrub_addr` equals the address being offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scrub_en | input | 1 | Start/hold zero-fill; gives the engine the port |
| tst_en | input | 1 | Gives the tester the port when scrub_en is low |
| tst_awaddr | input | ADDR_W | Tester write address |
| tst_awlen | input | 8 | Tester write burst length |
| tst_awvalid | input | 1 | Tester write address valid |
| tst_awready | output | 1 | Tester write address ready |
| tst_wdata | input | DATA_W | Tester write data |
| tst_wstrb | input | DATA_W/8 | Tester write strobes |
| tst_wlast | input | 1 | Tester last write beat |
| tst_wvalid | input | 1 | Tester write data valid |
| tst_wready | output | 1 | Tester write data ready |
| tst_bresp | output | 2 | Tester write response code |
| tst_bvalid | output | 1 | Tester write response valid |
| tst_bready | input | 1 | Tester write response ready |
| tst_araddr | input | ADDR_W | Tester read address |
| tst_arlen | input | 8 | Tester read burst length |
| tst_arvalid | input | 1 | Tester read address valid |
| tst_arready | output | 1 | Tester read address ready |
| tst_rdata | output | DATA_W | Tester read data |
| tst_rresp | output | 2 | Tester read response code |
| tst_rlast | output | 1 | Tester last read beat |
| tst_rvalid | output | 1 | Tester read data valid |
| tst_rready | input | 1 | Tester read data ready |
| host_awaddr | input | ADDR_W | Host write address |
| host_awlen | input | 8 | Host write burst length |
| host_awvalid | input | 1 | Host write address valid |
| host_awready | output | 1 | Host write address ready |
| host_wdata | input | DATA_W | Host write data |
| host_wstrb | input | DATA_W/8 | Host write strobes |
| host_wlast | input | 1 | Host last write beat |
| host_wvalid | input | 1 | Host write data valid |
| host_wready | output | 1 | Host write data ready |
| host_bresp | output | 2 | Host write response code |
| host_bvalid | output | 1 | Host write response valid |
| host_bready | input | 1 | Host write response ready |
| host_araddr | input | ADDR_W | Host read address |
| host_arlen | input | 8 | Host read burst length |
| host_arvalid | input | 1 | Host read address valid |
| host_arready | output | 1 | Host read address ready |
| host_rdata | output | DATA_W | Host read data |
| host_rresp | output | 2 | Host read response code |
| host_rlast | output | 1 | Host last read beat |
| host_rvalid | output | 1 | Host read data valid |
| host_rready | input | 1 | Host read data ready |
| mem_awaddr | output | ADDR_W | Memory write address |
| mem_awlen | output | 8 | Memory write burst length |
| mem_awvalid | output | 1 | Memory write address valid |
| mem_awready | input | 1 | Memory write address ready |
| mem_wdata | output | DATA_W | Memory write data |
| mem_wstrb | output | DATA_W/8 | Memory write strobes |
| mem_wlast | output | 1 | Memory last write beat |
| mem_wvalid | output | 1 | Memory write data valid |
| mem_wready | input | 1 | Memory write data ready |
| mem_bresp | input | 2 | Memory write response code |
| mem_bvalid | input | 1 | Memory write response valid |
| mem_bready | output | 1 | Memory write response ready |
| mem_araddr | output | ADDR_W | Memory read address |
| mem_arlen | output | 8 | Memory read burst length |
| mem_arvalid | output | 1 | Memory read address valid |
| mem_arready | input | 1 | Memory read address ready |
| mem_rdata | input | DATA_W | Memory read data |
| mem_rresp | input | 2 | Memory read response code |
| mem_rlast | input | 1 | Memory last read beat |
| mem_rvalid | input | 1 | Memory read data valid |
| mem_rready | output | 1 | Memory read data ready |
| scrub_state | output | 3 | Engine state code (0 IDLE, 1 ADDR, 2 DATA, 3 RESP, 4 DONE) |
| scrub_addr | output | ADDR_W | Base address of the current burst |
| scrub_done | output | 1 | Whole range cleared |
| scrub_err | output | 1 | Sticky: a non-OKAY write response was seen this run |

## Verification
A wrong address register shows at the next address handshake, where the offered address is not the burst index times 512. A wrong beat counter shows within one burst, as a `wlast` on the wrong beat or a length that is not 7 (or the shortened tail length). A stuck or skipped state shows at once in the state code, or one response later as a missing or premature done. A wrong ownership decode shows in the same cycle as a ready or valid leaking to a master that does not own the port.

// File: rtl/zf_pkg.sv
package zf_pkg;

    typedef enum logic [2:0] {
        ZF_IDLE = 3'd0,
        ZF_ADDR = 3'd1,
        ZF_DATA = 3'd2,
        ZF_RESP = 3'd3,
        ZF_DONE = 3'd4
    } zf_state_e;

    typedef enum logic [1:0] {
        OWN_ENGINE = 2'd0,
        OWN_TESTER = 2'd1,
        OWN_HOST   = 2'd2
    } owner_e;

    localparam int unsigned NUM_OWNERS = 3;
    localparam logic [1:0]  RESP_OKAY  = 2'b00;

endpackage

// File: rtl/zf_engine.sv
module zf_engine
    import zf_pkg::*;
#(
    parameter int unsigned ADDR_W      = 32,
    parameter int unsigned DATA_W      = 512,
    parameter int unsigned BURST_BEATS = 8,
    parameter int unsigned MAX_ADDR    = 32'h0000_04FF,
    localparam int unsigned STRB_W     = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    output logic [ADDR_W-1:0] awaddr,
    output logic [7:0]        awlen,
    output logic              awvalid,
    input  logic              awready,
    output logic [DATA_W-1:0] wdata,
    output logic [STRB_W-1:0] wstrb,
    output logic              wlast,
    output logic              wvalid,
    input  logic              wready,
    input  logic [1:0]        bresp,
    input  logic              bvalid,
    output logic              bready,
    output zf_state_e         state,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              done,
    output logic              err
);

    localparam int unsigned BEAT_BYTES  = DATA_W / 8;
    localparam int unsigned BEAT_SHIFT  = $clog2(BEAT_BYTES);
    localparam int unsigned BURST_BYTES = BEAT_BYTES * BURST_BEATS;
    localparam int unsigned CW          = ADDR_W + 1;
    localparam logic [CW-1:0] END_ADDR  = CW'(MAX_ADDR) + CW'(1);

    zf_state_e         state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic [7:0]        beat_q;
    logic [7:0]        len_q;
    logic              last_q;
    logic              err_q;

    logic [CW-1:0]     rem_beats;
    logic              last_burst;
    logic [7:0]        burst_len;

    // Beats left from the current base to the end of the region.
    assign rem_beats  = (END_ADDR - {1'b0, addr_q}) >> BEAT_SHIFT;
    assign last_burst = (rem_beats <= CW'(BURST_BEATS));
    assign burst_len  = last_burst ? 8'(rem_beats - CW'(1)) : 8'(BURST_BEATS - 1);

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ZF_IDLE;
        else        state_q <= state_d;
    end

    // Transitions: start, addr_accept, last_beat, next_burst, finish, release.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ZF_IDLE: if (en)                          state_d = ZF_ADDR;
            ZF_ADDR: if (awready)                     state_d = ZF_DATA;
            ZF_DATA: if (wready && beat_q == len_q)   state_d = ZF_RESP;
            ZF_RESP: if (bvalid)                      state_d = last_q ? ZF_DONE : ZF_ADDR;
            ZF_DONE: if (!en)                         state_d = ZF_IDLE;
            default:                                  state_d = ZF_IDLE;
        endcase
    end

    // Outputs decoded from the state.
    always_comb begin
        awvalid = 1'b0;
        wvalid  = 1'b0;
        bready  = 1'b0;
        done    = 1'b0;
        unique case (state_q)
            ZF_IDLE: ;
            ZF_ADDR: awvalid = 1'b1;
            ZF_DATA: wvalid  = 1'b1;
            ZF_RESP: bready  = 1'b1;
            ZF_DONE: done    = 1'b1;
            default: ;
        endcase
    end

    assign awaddr   = addr_q;
    assign awlen    = burst_len;
    assign wdata    = '0;
    assign wstrb    = '1;
    assign wlast    = wvalid && (beat_q == len_q);
    assign state    = state_q;
    assign cur_addr = addr_q;
    assign err      = err_q;

    // Address, beat and error bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            beat_q <= '0;
            len_q  <= '0;
            last_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            unique case (state_q)
                ZF_IDLE: if (en) begin
                    addr_q <= '0;
                    err_q  <= 1'b0;
                    beat_q <= '0;
                end
                ZF_ADDR: if (awready) begin
                    len_q  <= burst_len;
                    last_q <= last_burst;
                    beat_q <= '0;
                end
                ZF_DATA: if (wready) beat_q <= beat_q + 8'd1;
                ZF_RESP: if (bvalid) begin
                    if (bresp != RESP_OKAY) err_q <= 1'b1;
                    if (!last_q) addr_q <= addr_q + ADDR_W'(BURST_BYTES);
                end
                ZF_DONE: if (!en) addr_q <= '0;
                default: ;
            endcase
        end
    end

    // R5: an offered address holds value until accepted.
    p_aw_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (awvalid && !awready) |=> (awvalid && $stable(awaddr)));

    // R3: the base only ever moves forward by one burst while running.
    p_addr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ZF_RESP && bvalid && !last_q) |=> (addr_q == $past(addr_q) + ADDR_W'(BURST_BYTES)));

    // R3: no burst longer than the configured beat count.
    p_awlen_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        awvalid |-> (awlen <= 8'(BURST_BEATS - 1)));

    // R6: done persists while enable stays high.
    p_done_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && en) |=> done);

    // R7: error flag is sticky until a new run starts.
    p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (err_q && state_q != ZF_IDLE) |=> err_q);

endmodule

// File: rtl/zf_owner_sel.sv
module zf_owner_sel
    import zf_pkg::*;
(
    input  logic                  scrub_en,
    input  logic                  tst_en,
    output owner_e                owner,
    output logic [NUM_OWNERS-1:0] grant
);

    always_comb begin
        if (scrub_en)    owner = OWN_ENGINE;
        else if (tst_en) owner = OWN_TESTER;
        else             owner = OWN_HOST;
    end

    always_comb begin
        grant = '0;
        grant[owner] = 1'b1;
    end

endmodule

// File: rtl/zf_route.sv
module zf_route #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 512,
    parameter int unsigned NPATH  = 3,
    localparam int unsigned STRB_W = DATA_W / 8
) (
    input  logic [NPATH-1:0]  grant,
    input  logic [ADDR_W-1:0] p_awaddr  [NPATH],
    input  logic [7:0]        p_awlen   [NPATH],
    input  logic              p_awvalid [NPATH],
    output logic              p_awready [NPATH],
    input  logic [DATA_W-1:0] p_wdata   [NPATH],
    input  logic [STRB_W-1:0] p_wstrb   [NPATH],
    input  logic              p_wlast   [NPATH],
    input  logic              p_wvalid  [NPATH],
    output logic              p_wready  [NPATH],
    output logic [1:0]        p_bresp   [NPATH],
    output logic              p_bvalid  [NPATH],
    input  logic              p_bready  [NPATH],
    input  logic [ADDR_W-1:0] p_araddr  [NPATH],
    input  logic [7:0]        p_arlen   [NPATH],
    input  logic              p_arvalid [NPATH],
    output logic              p_arready [NPATH],
    output logic [DATA_W-1:0] p_rdata   [NPATH],
    output logic [1:0]        p_rresp   [NPATH],
    output logic              p_rlast   [NPATH],
    output logic              p_rvalid  [NPATH],
    input  logic              p_rready  [NPATH],
    output logic [ADDR_W-1:0] m_awaddr,
    output logic [7:0]        m_awlen,
    output logic              m_awvalid,
    input  logic              m_awready,
    output logic [DATA_W-1:0] m_wdata,
    output logic [STRB_W-1:0] m_wstrb,
    output logic              m_wlast,
    output logic              m_wvalid,
    input  logic              m_wready,
    input  logic [1:0]        m_bresp,
    input  logic              m_bvalid,
    output logic              m_bready,
    output logic [ADDR_W-1:0] m_araddr,
    output logic [7:0]        m_arlen,
    output logic              m_arvalid,
    input  logic              m_arready,
    input  logic [DATA_W-1:0] m_rdata,
    input  logic [1:0]        m_rresp,
    input  logic              m_rlast,
    input  logic              m_rvalid,
    output logic              m_rready
);

    // Requests: AND-OR over the one-hot grant.
    always_comb begin
        m_awaddr  = '0;
        m_awlen   = '0;
        m_awvalid = 1'b0;
        m_wdata   = '0;
        m_wstrb   = '0;
        m_wlast   = 1'b0;
        m_wvalid  = 1'b0;
        m_bready  = 1'b0;
        m_araddr  = '0;
        m_arlen   = '0;
        m_arvalid = 1'b0;
        m_rready  = 1'b0;
        for (int i = 0; i < int'(NPATH); i++) begin
            if (grant[i]) begin
                m_awaddr  = m_awaddr  | p_awaddr[i];
                m_awlen   = m_awlen   | p_awlen[i];
                m_awvalid = m_awvalid | p_awvalid[i];
                m_wdata   = m_wdata   | p_wdata[i];
                m_wstrb   = m_wstrb   | p_wstrb[i];
                m_wlast   = m_wlast   | p_wlast[i];
                m_wvalid  = m_wvalid  | p_wvalid[i];
                m_bready  = m_bready  | p_bready[i];
                m_araddr  = m_araddr  | p_araddr[i];
                m_arlen   = m_arlen   | p_arlen[i];
                m_arvalid = m_arvalid | p_arvalid[i];
                m_rready  = m_rready  | p_rready[i];
            end
        end
    end

    // Responses: payload fans out, handshake bits only to the owner.
    for (genvar g = 0; g < int'(NPATH); g++) begin : g_resp
        assign p_awready[g] = grant[g] & m_awready;
        assign p_wready[g]  = grant[g] & m_wready;
        assign p_arready[g] = grant[g] & m_arready;
        assign p_bvalid[g]  = grant[g] & m_bvalid;
        assign p_rvalid[g]  = grant[g] & m_rvalid;
        assign p_bresp[g]   = m_bresp;
        assign p_rdata[g]   = m_rdata;
        assign p_rresp[g]   = m_rresp;
        assign p_rlast[g]   = m_rlast;
    end

endmodule

// File: rtl/mem_zero_fill.sv
module mem_zero_fill
    import zf_pkg::*;
#(
    parameter int unsigned ADDR_W      = 32,
    parameter int unsigned DATA_W      = 512,
    parameter int unsigned BURST_BEATS = 8,
    parameter int unsigned MAX_ADDR    = 32'h0000_04FF,
    localparam int unsigned STRB_W     = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scrub_en,
    input  logic              tst_en,
    input  logic [ADDR_W-1:0] tst_awaddr,
    input  logic [7:0]        tst_awlen,
    input  logic              tst_awvalid,
    output logic              tst_awready,
    input  logic [DATA_W-1:0] tst_wdata,
    input  logic [STRB_W-1:0] tst_wstrb,
    input  logic              tst_wlast,
    input  logic              tst_wvalid,
    output logic              tst_wready,
    output logic [1:0]        tst_bresp,
    output logic              tst_bvalid,
    input  logic              tst_bready,
    input  logic [ADDR_W-1:0] tst_araddr,
    input  logic [7:0]        tst_arlen,
    input  logic              tst_arvalid,
    output logic              tst_arready,
    output logic [DATA_W-1:0] tst_rdata,
    output logic [1:0]        tst_rresp,
    output logic              tst_rlast,
    output logic              tst_rvalid,
    input  logic              tst_rready,
    input  logic [ADDR_W-1:0] host_awaddr,
    input  logic [7:0]        host_awlen,
    input  logic              host_awvalid,
    output logic              host_awready,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic [STRB_W-1:0] host_wstrb,
    input  logic              host_wlast,
    input  logic              host_wvalid,
    output logic              host_wready,
    output logic [1:0]        host_bresp,
    output logic              host_bvalid,
    input  logic              host_bready,
    input  logic [ADDR_W-1:0] host_araddr,
    input  logic [7:0]        host_arlen,
    input  logic              host_arvalid,
    output logic              host_arready,
    output logic [DATA_W-1:0] host_rdata,
    output logic [1:0]        host_rresp,
    output logic              host_rlast,
    output logic              host_rvalid,
    input  logic              host_rready,
    output logic [ADDR_W-1:0] mem_awaddr,
    output logic [7:0]        mem_awlen,
    output logic              mem_awvalid,
    input  logic              mem_awready,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [STRB_W-1:0] mem_wstrb,
    output logic              mem_wlast,
    output logic              mem_wvalid,
    input  logic              mem_wready,
    input  logic [1:0]        mem_bresp,
    input  logic              mem_bvalid,
    output logic              mem_bready,
    output logic [ADDR_W-1:0] mem_araddr,
    output logic [7:0]        mem_arlen,
    output logic              mem_arvalid,
    input  logic              mem_arready,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic [1:0]        mem_rresp,
    input  logic              mem_rlast,
    input  logic              mem_rvalid,
    output logic              mem_rready,
    output logic [2:0]        scrub_state,
    output logic [ADDR_W-1:0] scrub_addr,
    output logic              scrub_done,
    output logic              scrub_err
);

    localparam int unsigned IE = int'(OWN_ENGINE);
    localparam int unsigned IT = int'(OWN_TESTER);
    localparam int unsigned IH = int'(OWN_HOST);

    owner_e                owner;
    logic [NUM_OWNERS-1:0] grant;
    zf_state_e             eng_state;

    logic [ADDR_W-1:0] p_awaddr  [NUM_OWNERS];
    logic [7:0]        p_awlen   [NUM_OWNERS];
    logic              p_awvalid [NUM_OWNERS];
    logic              p_awready [NUM_OWNERS];
    logic [DATA_W-1:0] p_wdata   [NUM_OWNERS];
    logic [STRB_W-1:0] p_wstrb   [NUM_OWNERS];
    logic              p_wlast   [NUM_OWNERS];
    logic              p_wvalid  [NUM_OWNERS];
    logic              p_wready  [NUM_OWNERS];
    logic [1:0]        p_bresp   [NUM_OWNERS];
    logic              p_bvalid  [NUM_OWNERS];
    logic              p_bready  [NUM_OWNERS];
    logic [ADDR_W-1:0] p_araddr  [NUM_OWNERS];
    logic [7:0]        p_arlen   [NUM_OWNERS];
    logic              p_arvalid [NUM_OWNERS];
    logic              p_arready [NUM_OWNERS];
    logic [DATA_W-1:0] p_rdata   [NUM_OWNERS];
    logic [1:0]        p_rresp   [NUM_OWNERS];
    logic              p_rlast   [NUM_OWNERS];
    logic              p_rvalid  [NUM_OWNERS];
    logic              p_rready  [NUM_OWNERS];

    zf_owner_sel u_sel (
        .scrub_en (scrub_en),
        .tst_en   (tst_en),
        .owner    (owner),
        .grant    (grant)
    );

    zf_engine #(
        .ADDR_W      (ADDR_W),
        .DATA_W      (DATA_W),
        .BURST_BEATS (BURST_BEATS),
        .MAX_ADDR    (MAX_ADDR)
    ) u_engine (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (scrub_en),
        .awaddr   (p_awaddr[IE]),
        .awlen    (p_awlen[IE]),
        .awvalid  (p_awvalid[IE]),
        .awready  (p_awready[IE]),
        .wdata    (p_wdata[IE]),
        .wstrb    (p_wstrb[IE]),
        .wlast    (p_wlast[IE]),
        .wvalid   (p_wvalid[IE]),
        .wready   (p_wready[IE]),
        .bresp    (p_bresp[IE]),
        .bvalid   (p_bvalid[IE]),
        .bready   (p_bready[IE]),
        .state    (eng_state),
        .cur_addr (scrub_addr),
        .done     (scrub_done),
        .err      (scrub_err)
    );

    // The engine only writes; its read side is idle.
    assign p_araddr[IE]  = '0;
    assign p_arlen[IE]   = '0;
    assign p_arvalid[IE] = 1'b0;
    assign p_rready[IE]  = 1'b0;

    assign p_awaddr[IT]  = tst_awaddr;
    assign p_awlen[IT]   = tst_awlen;
    assign p_awvalid[IT] = tst_awvalid;
    assign p_wdata[IT]   = tst_wdata;
    assign p_wstrb[IT]   = tst_wstrb;
    assign p_wlast[IT]   = tst_wlast;
    assign p_wvalid[IT]  = tst_wvalid;
    assign p_bready[IT]  = tst_bready;
    assign p_araddr[IT]  = tst_araddr;
    assign p_arlen[IT]   = tst_arlen;
    assign p_arvalid[IT] = tst_arvalid;
    assign p_rready[IT]  = tst_rready;
    assign tst_awready   = p_awready[IT];
    assign tst_wready    = p_wready[IT];
    assign tst_bresp     = p_bresp[IT];
    assign tst_bvalid    = p_bvalid[IT];
    assign tst_arready   = p_arready[IT];
    assign tst_rdata     = p_rdata[IT];
    assign tst_rresp     = p_rresp[IT];
    assign tst_rlast     = p_rlast[IT];
    assign tst_rvalid    = p_rvalid[IT];

    assign p_awaddr[IH]  = host_awaddr;
    assign p_awlen[IH]   = host_awlen;
    assign p_awvalid[IH] = host_awvalid;
    assign p_wdata[IH]   = host_wdata;
    assign p_wstrb[IH]   = host_wstrb;
    assign p_wlast[IH]   = host_wlast;
    assign p_wvalid[IH]  = host_wvalid;
    assign p_bready[IH]  = host_bready;
    assign p_araddr[IH]  = host_araddr;
    assign p_arlen[IH]   = host_arlen;
    assign p_arvalid[IH] = host_arvalid;
    assign p_rready[IH]  = host_rready;
    assign host_awready  = p_awready[IH];
    assign host_wready   = p_wready[IH];
    assign host_bresp    = p_bresp[IH];
    assign host_bvalid   = p_bvalid[IH];
    assign host_arready  = p_arready[IH];
    assign host_rdata    = p_rdata[IH];
    assign host_rresp    = p_rresp[IH];
    assign host_rlast    = p_rlast[IH];
    assign host_rvalid   = p_rvalid[IH];

    zf_route #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .NPATH  (NUM_OWNERS)
    ) u_route (
        .grant     (grant),
        .p_awaddr  (p_awaddr),
        .p_awlen   (p_awlen),
        .p_awvalid (p_awvalid),
        .p_awready (p_awready),
        .p_wdata   (p_wdata),
        .p_wstrb   (p_wstrb),
        .p_wlast   (p_wlast),
        .p_wvalid  (p_wvalid),
        .p_wready  (p_wready),
        .p_bresp   (p_bresp),
        .p_bvalid  (p_bvalid),
        .p_bready  (p_bready),
        .p_araddr  (p_araddr),
        .p_arlen   (p_arlen),
        .p_arvalid (p_arvalid),
        .p_arready (p_arready),
        .p_rdata   (p_rdata),
        .p_rresp   (p_rresp),
        .p_rlast   (p_rlast),
        .p_rvalid  (p_rvalid),
        .p_rready  (p_rready),
        .m_awaddr  (mem_awaddr),
        .m_awlen   (mem_awlen),
        .m_awvalid (mem_awvalid),
        .m_awready (mem_awready),
        .m_wdata   (mem_wdata),
        .m_wstrb   (mem_wstrb),
        .m_wlast   (mem_wlast),
        .m_wvalid  (mem_wvalid),
        .m_wready  (mem_wready),
        .m_bresp   (mem_bresp),
        .m_bvalid  (mem_bvalid),
        .m_bready  (mem_bready),
        .m_araddr  (mem_araddr),
        .m_arlen   (mem_arlen),
        .m_arvalid (mem_arvalid),
        .m_arready (mem_arready),
        .m_rdata   (mem_rdata),
        .m_rresp   (mem_rresp),
        .m_rlast   (mem_rlast),
        .m_rvalid  (mem_rvalid),
        .m_rready  (mem_rready)
    );

    assign scrub_state = eng_state;

    // R8: the engine wins the port whenever it is enabled.
    p_engine_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        scrub_en |-> (mem_awvalid == p_awvalid[IE] && mem_wvalid == p_wvalid[IE]
                      && mem_bready == p_bready[IE] && !mem_arvalid));

    // R9: tester sees no handshake while it does not own the port.
    p_tester_blocked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (scrub_en || !tst_en) |-> !(tst_awready || tst_wready || tst_arready
                                    || tst_bvalid || tst_rvalid));

    // R9: host sees no handshake while either enable is high.
    p_host_blocked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (scrub_en || tst_en) |-> !(host_awready || host_wready || host_arready
                                   || host_bvalid || host_rvalid));

    // R10: only the five defined codes ever appear.
    p_state_legal_r10: assert property (@(posedge clk) disable iff (!rst_n)
        scrub_state <= 3'd4);

endmodule

// File: tb/test_mem_zero_fill.sv
module test_mem_zero_fill;

    localparam int unsigned ADDR_W = 32;
    localparam int unsigned DATA_W = 512;
    localparam int unsigned STRB_W = DATA_W / 8;
    localparam int unsigned MAXA   = 32'h0000_04FF;
    localparam int          TOTAL  = (MAXA + 1) / 64;   // 20 beats
    localparam int          NBURST = (TOTAL + 7) / 8;   // 3 bursts

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scrub_en = 1'b0, tst_en = 1'b0;

    logic [ADDR_W-1:0] tst_awaddr = 32'h1111, tst_araddr = 32'h1180;
    logic [7:0]        tst_awlen = 8'd3, tst_arlen = 8'd1;
    logic              tst_awvalid = 1'b1, tst_wvalid = 1'b1, tst_arvalid = 1'b1;
    logic [DATA_W-1:0] tst_wdata = '1;
    logic [STRB_W-1:0] tst_wstrb = '1;
    logic              tst_wlast = 1'b1, tst_bready = 1'b1, tst_rready = 1'b1;
    logic              tst_awready, tst_wready, tst_bvalid, tst_arready, tst_rlast, tst_rvalid;
    logic [1:0]        tst_bresp, tst_rresp;
    logic [DATA_W-1:0] tst_rdata;

    logic [ADDR_W-1:0] host_awaddr = 32'h2222, host_araddr = 32'h2280;
    logic [7:0]        host_awlen = 8'd5, host_arlen = 8'd2;
    logic              host_awvalid = 1'b1, host_wvalid = 1'b1, host_arvalid = 1'b1;
    logic [DATA_W-1:0] host_wdata = '1;
    logic [STRB_W-1:0] host_wstrb = '1;
    logic              host_wlast = 1'b0, host_bready = 1'b0, host_rready = 1'b1;
    logic              host_awready, host_wready, host_bvalid, host_arready, host_rlast, host_rvalid;
    logic [1:0]        host_bresp, host_rresp;
    logic [DATA_W-1:0] host_rdata;

    logic [ADDR_W-1:0] mem_awaddr, mem_araddr;
    logic [7:0]        mem_awlen, mem_arlen;
    logic              mem_awvalid, mem_wlast, mem_wvalid, mem_bready, mem_arvalid, mem_rready;
    logic [DATA_W-1:0] mem_wdata;
    logic [STRB_W-1:0] mem_wstrb;
    logic              mem_awready = 1'b0, mem_wready = 1'b0, mem_bvalid = 1'b0;
    logic              mem_arready = 1'b0, mem_rvalid = 1'b0, mem_rlast = 1'b0;
    logic [1:0]        mem_bresp = 2'b00, mem_rresp = 2'b00;
    logic [DATA_W-1:0] mem_rdata = '0;

    logic [2:0]        scrub_state;
    logic [ADDR_W-1:0] scrub_addr;
    logic              scrub_done, scrub_err;

    mem_zero_fill #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BURST_BEATS(8), .MAX_ADDR(MAXA)) i_mem_zero_fill (
        .clk(clk), .rst_n(rst_n), .scrub_en(scrub_en), .tst_en(tst_en),
        .tst_awaddr(tst_awaddr), .tst_awlen(tst_awlen), .tst_awvalid(tst_awvalid), .tst_awready(tst_awready),
        .tst_wdata(tst_wdata), .tst_wstrb(tst_wstrb), .tst_wlast(tst_wlast), .tst_wvalid(tst_wvalid),
        .tst_wready(tst_wready), .tst_bresp(tst_bresp), .tst_bvalid(tst_bvalid), .tst_bready(tst_bready),
        .tst_araddr(tst_araddr), .tst_arlen(tst_arlen), .tst_arvalid(tst_arvalid), .tst_arready(tst_arready),
        .tst_rdata(tst_rdata), .tst_rresp(tst_rresp), .tst_rlast(tst_rlast), .tst_rvalid(tst_rvalid),
        .tst_rready(tst_rready),
        .host_awaddr(host_awaddr), .host_awlen(host_awlen), .host_awvalid(host_awvalid), .host_awready(host_awready),
        .host_wdata(host_wdata), .host_wstrb(host_wstrb), .host_wlast(host_wlast), .host_wvalid(host_wvalid),
        .host_wready(host_wready), .host_bresp(host_bresp), .host_bvalid(host_bvalid), .host_bready(host_bready),
        .host_araddr(host_araddr), .host_arlen(host_arlen), .host_arvalid(host_arvalid), .host_arready(host_arready),
        .host_rdata(host_rdata), .host_rresp(host_rresp), .host_rlast(host_rlast), .host_rvalid(host_rvalid),
        .host_rready(host_rready),
        .mem_awaddr(mem_awaddr), .mem_awlen(mem_awlen), .mem_awvalid(mem_awvalid), .mem_awready(mem_awready),
        .mem_wdata(mem_wdata), .mem_wstrb(mem_wstrb), .mem_wlast(mem_wlast), .mem_wvalid(mem_wvalid),
        .mem_wready(mem_wready), .mem_bresp(mem_bresp), .mem_bvalid(mem_bvalid), .mem_bready(mem_bready),
        .mem_araddr(mem_araddr), .mem_arlen(mem_arlen), .mem_arvalid(mem_arvalid), .mem_arready(mem_arready),
        .mem_rdata(mem_rdata), .mem_rresp(mem_rresp), .mem_rlast(mem_rlast), .mem_rvalid(mem_rvalid),
        .mem_rready(mem_rready),
        .scrub_state(scrub_state), .scrub_addr(scrub_addr), .scrub_done(scrub_done), .scrub_err(scrub_err)
    );

    always #2 clk = ~clk;   // 250 MHz

    int n_cmp = 0, n_bad = 0;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int exp_len(input int k);
        int rem = TOTAL - 8 * k;
        return ((rem > 8) ? 8 : rem) - 1;
    endfunction

    // Memory-side responder and protocol monitor.
    bit force_mode = 1'b0;
    int cyc = 0, naw = 0, nb = 0, beat = 0, cur_len = 0, outst = 0, err_burst = -1;
    bit b_arm = 1'b0, b_drop = 1'b0;

    always begin
        @(negedge clk);
        cyc++;
        if (force_mode) begin
            mem_awready = 1'b1; mem_wready = 1'b1; mem_arready = 1'b1;
            mem_bvalid  = 1'b1; mem_rvalid = 1'b1; mem_rlast  = 1'b1;
            mem_bresp   = 2'b00; mem_rdata = '1;
        end else begin
            mem_awready = (cyc % 3 != 0);
            mem_wready  = (cyc % 4 != 1);
            mem_arready = 1'b0; mem_rvalid = 1'b0; mem_rlast = 1'b0;
            if (b_drop) begin mem_bvalid = 1'b0; b_drop = 1'b0; end
            if (b_arm) begin
                mem_bvalid = 1'b1;
                mem_bresp  = (nb == err_burst) ? 2'b10 : 2'b00;
                b_arm = 1'b0;
            end
        end
        #1;
        if (!force_mode && scrub_en && rst_n) begin
            if (mem_awvalid) begin
                check(scrub_state == 3'd1, "R10 state code while address offered", scrub_state, 1);
                check(scrub_addr == mem_awaddr, "R10 status address", scrub_addr, mem_awaddr);
            end
            if (mem_awvalid && mem_awready) begin
                check(mem_awaddr == ADDR_W'(naw * 512), "R3 burst address", mem_awaddr, naw * 512);
                check(int'(mem_awlen) == exp_len(naw), "R3 burst length", mem_awlen, exp_len(naw));
                check(outst == 0, "R5 address offered with a burst outstanding", outst, 0);
                outst = 1; cur_len = int'(mem_awlen); beat = 0; naw++;
            end
            if (mem_wvalid) check(scrub_state == 3'd2, "R10 state code during data", scrub_state, 2);
            if (mem_wvalid && mem_wready) begin
                check(mem_wdata == '0 && mem_wstrb == '1, "R4 zero data with full strobes",
                      longint'(mem_wdata[63:0]), 0);
                check(mem_wlast == (beat == cur_len), "R4 wlast position", mem_wlast, beat == cur_len);
                if (mem_wlast) b_arm = 1'b1;
                beat++;
            end
            if (mem_bvalid && mem_bready) begin
                check(scrub_state == 3'd3, "R10 state code during response", scrub_state, 3);
                outst = 0; nb++; b_drop = 1'b1;
            end
        end
    end

    task automatic wait_done();
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (scrub_done) break;
        end
        #1;
    endtask

    task automatic restart_counts();
        naw = 0; nb = 0; outst = 0; beat = 0;
    endtask

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        // R1: reset state
        check(scrub_state == 3'd0, "R1 state after reset", scrub_state, 0);
        check(scrub_addr == '0, "R1 address after reset", scrub_addr, 0);
        check(!scrub_done && !scrub_err, "R1 done/err after reset", {scrub_done, scrub_err}, 0);

        // R2: start
        restart_counts();
        @(negedge clk); scrub_en = 1'b1;
        @(negedge clk); #1;
        check(scrub_state == 3'd1, "R2 state after start", scrub_state, 1);
        check(mem_awvalid && mem_awaddr == '0, "R2 first burst at address 0", mem_awaddr, 0);

        // R3/R4/R5 checked by the monitor; R6 completion
        wait_done();
        check(scrub_state == 3'd4 && scrub_done, "R6 done state", scrub_state, 4);
        check(naw == NBURST && nb == NBURST, "R3 burst count over the range", naw, NBURST);
        check(!scrub_err, "R7 no error on clean run", scrub_err, 0);
        repeat (5) @(negedge clk);
        #1;
        check(scrub_done && scrub_state == 3'd4 && !mem_awvalid, "R6 done held while enabled", scrub_state, 4);
        check(scrub_addr == ADDR_W'((NBURST - 1) * 512), "R10 address holds last base", scrub_addr, (NBURST - 1) * 512);
        @(negedge clk); scrub_en = 1'b0;
        @(negedge clk); #1;
        check(scrub_state == 3'd0 && !scrub_done, "R6 release to idle", scrub_state, 0);
        check(scrub_addr == '0, "R6 address cleared on release", scrub_addr, 0);

        // R7: error on the middle burst
        restart_counts(); err_burst = 1;
        @(negedge clk); scrub_en = 1'b1;
        wait_done();
        check(scrub_err, "R7 sticky error after bad response", scrub_err, 1);
        check(naw == NBURST && nb == NBURST, "R7 clear continues after error", naw, NBURST);
        @(negedge clk); scrub_en = 1'b0;
        @(negedge clk);
        check(scrub_err, "R7 error held through release", scrub_err, 1);
        restart_counts(); err_burst = -1;
        scrub_en = 1'b1;
        @(negedge clk); #1;
        check(!scrub_err && scrub_state == 3'd1, "R7 error cleared on new start", scrub_err, 0);
        wait_done();
        check(!scrub_err && naw == NBURST, "R7 clean rerun", scrub_err, 0);
        @(negedge clk); scrub_en = 1'b0;
        repeat (3) @(negedge clk);

        // R8/R9: exhaustive sweep of both enables with the engine idle
        force_mode = 1'b1;
        @(negedge clk);
        for (int s = 0; s < 2; s++) begin
            for (int t = 0; t < 2; t++) begin
                int own;
                logic [ADDR_W-1:0] ea;
                @(negedge clk);
                scrub_en = s[0]; tst_en = t[0];
                #1;
                own = (s == 1) ? 0 : ((t == 1) ? 1 : 2);
                ea  = (own == 0) ? '0 : ((own == 1) ? tst_awaddr : host_awaddr);
                check(mem_awaddr == ea, $sformatf("R8 awaddr owner s=%0d t=%0d", s, t), mem_awaddr, ea);
                check(mem_awvalid == (own != 0), $sformatf("R8 awvalid s=%0d t=%0d", s, t), mem_awvalid, own != 0);
                check(mem_arvalid == (own != 0), $sformatf("R8 arvalid s=%0d t=%0d", s, t), mem_arvalid, own != 0);
                check(mem_bready == (own == 1), $sformatf("R8 bready s=%0d t=%0d", s, t), mem_bready, own == 1);
                check({tst_awready, tst_wready, tst_arready, tst_bvalid, tst_rvalid} == {5{own == 1}},
                      $sformatf("R9 tester handshakes s=%0d t=%0d", s, t),
                      {tst_awready, tst_wready, tst_arready, tst_bvalid, tst_rvalid}, (own == 1) ? 31 : 0);
                check({host_awready, host_wready, host_arready, host_bvalid, host_rvalid} == {5{own == 2}},
                      $sformatf("R9 host handshakes s=%0d t=%0d", s, t),
                      {host_awready, host_wready, host_arready, host_bvalid, host_rvalid}, (own == 2) ? 31 : 0);
                scrub_en = 1'b0;   // withdrawn before the next edge
            end
        end
        @(negedge clk); #1;
        check(scrub_state == 3'd0, "R8 engine stayed idle during sweep", scrub_state, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule